// File: doc/BRIEF.md
# Disk Controller Host Register Interface

This block is the host-facing register file of a single-sector hard/floppy disk controller. An 8-bit processor reaches it through eight consecutive I/O port offsets, selected by a 3-bit port number with separate read and write strobes that stay high for several clocks. The block holds the task-file registers (sector count, sector number, 16-bit track, size/drive/head), decodes the drive-select field into a hard-disk or floppy layout, and moves sector bytes between the host and an external 512-byte dual-port buffer RAM through a 9-bit address counter.

Commands are written to offset 7. A sector read (0x20) raises an execution request to a separate command sequencer at once. A sector write (0x30) first opens the data port so that the host can fill the buffer, and raises the request only when the 512th byte lands. The sequencer answers with a completion pulse and a result code. The block then updates busy, data-request and error status and the error register, which the host polls through offset 7 and offset 1.

Top module: `dkc_host_regs`

## Requirements
- R1: Offsets 2 to 6 are read/write registers: 2 sector count, 3 sector number, 4 track low byte, 5 track high byte, 6 size/drive/head. A write to offset 1 has no effect, and offset 1 reads the error register.
- R2: Size/drive/head bits 4-3 select the drive. For the values 0 to 2, `floppy_o`=0, `drive_o`=bits 4-3 and `head_o`=bits 2-0. For the value 3, `floppy_o`=1, `drive_o`=bits 2-1 and `head_o`=bit 0, zero-extended. `track_o`={offset 5, offset 4} and `sector_o`=offset 3.
- R3: Each strobe takes effect once, on its rising edge, however many clocks it stays high.
- R4: Writing 0x20 to offset 7 when not busy sets busy and pulses `exec_req_o` for one clock with `exec_cmd_o`=0x20.
- R5: While data request is set in read mode, each read of offset 0 returns `buf_rdata_i` and advances `buf_addr_o` by one on the following clock. The read that is made at address 511 clears data request.
- R6: Writing 0x30 to offset 7 when not busy sets data request. Each write to offset 0 drives `buf_we_o` for one clock with the byte at the current address, and the address then advances. The write at address 511 clears data request, sets busy and pulses `exec_req_o` with `exec_cmd_o`=0x30.
- R7: A write to offset 7 while busy is ignored: no request is raised and the status does not change.
- R8: Any command that is accepted resets the buffer address to 0. Data-port accesses while data request is clear do not move the address.
- R9: A command code other than 0x20 or 0x30 sets the status error bit and error register bit 2 (abort), and raises no request.
- R10: `exec_done_i` while busy clears busy. With result 0 (OK) after a read, data request sets. With result 1 (geometry fault), error register bit 4 is set. With result 2 or 3 (storage fault), bit 6 is set. In both fault cases the status error bit sets. A later accepted command clears both. `exec_done_i` while not busy is ignored.
- R11: The status byte reads bit 7 busy, bit 6 ready (1), bit 5 0, bit 4 seek complete (1), bit 3 data request, bits 2-1 0, bit 0 error. After reset, status reads 0x50, and all registers and the buffer address are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_sel_i | input | 3 | Port offset 0..7 |
| rd_i | input | 1 | Host read strobe (level, multi-cycle) |
| wr_i | input | 1 | Host write strobe (level, multi-cycle) |
| din_i | input | 8 | Host write data |
| dout_o | output | 8 | Host read data for the selected offset |
| buf_addr_o | output | 9 | Buffer RAM address |
| buf_we_o | output | 1 | Buffer RAM write enable |
| buf_wdata_o | output | 8 | Buffer RAM write data |
| buf_rdata_i | input | 8 | Buffer RAM read data (synchronous RAM) |
| exec_req_o | output | 1 | One-cycle execution request to the sequencer |
| exec_cmd_o | output | 8 | Command code for the request |
| exec_done_i | input | 1 | Completion pulse from the sequencer |
| exec_result_i | input | 2 | 0 OK, 1 geometry fault, 2/3 storage fault |
| floppy_o | output | 1 | Floppy layout selected |
| drive_o | output | 2 | Decoded drive number |
| head_o | output | 3 | Decoded head number |
| track_o | output | 16 | Track number |
| sector_o | output | 8 | Sector number |

## Verification
If the address counter skips or repeats a step, the error shows on the very next data-port read as a wrong byte. It also moves the request to the 511th or 513th write, which a check at those two boundaries catches. If busy or data request sticks, the next status poll shows a wrong byte within one access, and a missed or doubled request shows as a count mismatch on the request monitor. If the strobe edge detection is broken, a long-held strobe moves the address by more than one at once.

// File: rtl/dkc_pkg.sv
package dkc_pkg;
  typedef enum logic [2:0] {
    P_DATA = 3'd0, P_ERR = 3'd1, P_SCNT = 3'd2, P_SNUM = 3'd3,
    P_TRK_LO = 3'd4, P_TRK_HI = 3'd5, P_SDH = 3'd6, P_CMD = 3'd7
  } port_e;

  typedef enum logic [1:0] {
    RES_OK = 2'd0, RES_GEO = 2'd1, RES_STORE = 2'd2, RES_STORE2 = 2'd3
  } result_e;

  localparam logic [7:0] CMD_RD = 8'h20;
  localparam logic [7:0] CMD_WR = 8'h30;

  localparam int ERR_ABORT_BIT = 2;
  localparam int ERR_GEO_BIT   = 4;
  localparam int ERR_STORE_BIT = 6;
endpackage

// File: rtl/dkc_strobe_edge.sv
module dkc_strobe_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic rise_o
);
  logic level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= 1'b0;
    else         level_q <= level_i;
  end

  assign rise_o = level_i & ~level_q;

  // R3
  single_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/dkc_buf_ptr.sv
module dkc_buf_ptr #(
  parameter int ADDR_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              pend_q;
  logic [ADDR_W:0]   addr_inc;

  assign addr_inc = {1'b0, addr_q} + {{ADDR_W{1'b0}}, 1'b1};

  // address moves one clock after the access
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      pend_q <= 1'b0;
    end else if (clear_i) begin
      addr_q <= '0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= step_i;
      if (pend_q) addr_q <= addr_inc[ADDR_W-1:0];
    end
  end

  assign addr_o = addr_q;
  assign last_o = addr_inc[ADDR_W];

  // R5
  step_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !clear_i) |=> addr_q == $past(addr_inc[ADDR_W-1:0]));

  // R8
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> addr_q == '0);
endmodule

// File: rtl/dkc_task_file.sv
module dkc_task_file
  import dkc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        sel_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              floppy_o,
  output logic [1:0]        drive_o,
  output logic [2:0]        head_o,
  output logic [2*DATA_W-1:0] track_o,
  output logic [DATA_W-1:0] sector_o
);
  localparam int REG_LO = int'(P_SCNT);
  localparam int REG_HI = int'(P_SDH);

  logic [DATA_W-1:0] regs_q [REG_LO:REG_HI];
  logic [DATA_W-1:0] sdh;

  for (genvar g = REG_LO; g <= REG_HI; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            regs_q[g] <= '0;
      else if (wr_en_i && int'(sel_i) == g)   regs_q[g] <= din_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = REG_LO; i <= REG_HI; i++)
      if (int'(sel_i) == i) rdata_o = regs_q[i];
  end

  assign sdh      = regs_q[REG_HI];
  assign floppy_o = &sdh[4:3];
  assign drive_o  = floppy_o ? sdh[2:1] : sdh[4:3];
  assign head_o   = floppy_o ? {2'b00, sdh[0]} : sdh[2:0];
  assign track_o  = {regs_q[int'(P_TRK_HI)], regs_q[int'(P_TRK_LO)]};
  assign sector_o = regs_q[int'(P_SNUM)];
endmodule

// File: rtl/dkc_cmd_ctl.sv
module dkc_cmd_ctl
  import dkc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_wr_i,
  input  logic              data_rd_i,
  input  logic              data_wr_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              buf_last_i,
  input  logic              done_i,
  input  logic [1:0]        result_i,
  output logic              busy_o,
  output logic              drq_o,
  output logic              err_o,
  output logic [DATA_W-1:0] err_reg_o,
  output logic              exec_req_o,
  output logic [DATA_W-1:0] exec_cmd_o,
  output logic              ptr_clear_o,
  output logic              ptr_step_o,
  output logic              buf_we_o,
  output logic [DATA_W-1:0] buf_wdata_o
);
  logic busy_q, drq_q, wr_phase_q, err_q, req_q, we_q;
  logic [DATA_W-1:0] err_reg_q, cmd_q, wdata_q;
  logic accept, rd_ok, wr_ok;

  assign accept = cmd_wr_i & ~busy_q;
  assign rd_ok  = data_rd_i & drq_q & ~wr_phase_q;
  assign wr_ok  = data_wr_i & drq_q &  wr_phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; drq_q <= 1'b0; wr_phase_q <= 1'b0; err_q <= 1'b0;
      req_q <= 1'b0; we_q <= 1'b0;
      err_reg_q <= '0; cmd_q <= '0; wdata_q <= '0;
    end else begin
      req_q <= 1'b0;
      we_q  <= 1'b0;
      if (done_i && busy_q) begin
        busy_q <= 1'b0;
        if (result_e'(result_i) == RES_OK) begin
          if (cmd_q == CMD_RD) begin
            drq_q      <= 1'b1;
            wr_phase_q <= 1'b0;
          end
        end else begin
          err_q <= 1'b1;
          err_reg_q <= '0;
          if (result_e'(result_i) == RES_GEO) err_reg_q[ERR_GEO_BIT]   <= 1'b1;
          else                                err_reg_q[ERR_STORE_BIT] <= 1'b1;
        end
      end else if (accept) begin
        err_q     <= 1'b0;
        err_reg_q <= '0;
        unique case (din_i)
          CMD_RD: begin
            busy_q <= 1'b1; drq_q <= 1'b0; wr_phase_q <= 1'b0;
            req_q  <= 1'b1; cmd_q <= din_i;
          end
          CMD_WR: begin
            drq_q <= 1'b1; wr_phase_q <= 1'b1; cmd_q <= din_i;
          end
          default: begin
            drq_q <= 1'b0;
            err_q <= 1'b1;
            err_reg_q[ERR_ABORT_BIT] <= 1'b1;
          end
        endcase
      end else begin
        if (rd_ok && buf_last_i) drq_q <= 1'b0;
        if (wr_ok) begin
          we_q    <= 1'b1;
          wdata_q <= din_i;
          if (buf_last_i) begin
            drq_q  <= 1'b0;
            busy_q <= 1'b1;
            req_q  <= 1'b1;
          end
        end
      end
    end
  end

  assign busy_o      = busy_q;
  assign drq_o       = drq_q;
  assign err_o       = err_q;
  assign err_reg_o   = err_reg_q;
  assign exec_req_o  = req_q;
  assign exec_cmd_o  = cmd_q;
  assign ptr_clear_o = accept;
  assign ptr_step_o  = rd_ok | wr_ok;
  assign buf_we_o    = we_q;
  assign buf_wdata_o = wdata_q;

  // R4
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> !req_q);

  // R4
  req_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> busy_q);

  // R7
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cmd_wr_i && !done_i) |=> (busy_q && !req_q));

  // R10
  busy_drq_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_q && drq_q));

  // R5
  drq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(drq_q) |-> ($past(buf_last_i) || $past(cmd_wr_i)));

  // R9
  err_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> $countones(err_reg_q) == 1);
endmodule

// File: rtl/dkc_host_regs.sv
module dkc_host_regs
  import dkc_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BUF_BYTES = 512,
  localparam int ADDR_W   = $clog2(BUF_BYTES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2:0]          port_sel_i,
  input  logic                rd_i,
  input  logic                wr_i,
  input  logic [DATA_W-1:0]   din_i,
  output logic [DATA_W-1:0]   dout_o,
  output logic [ADDR_W-1:0]   buf_addr_o,
  output logic                buf_we_o,
  output logic [DATA_W-1:0]   buf_wdata_o,
  input  logic [DATA_W-1:0]   buf_rdata_i,
  output logic                exec_req_o,
  output logic [DATA_W-1:0]   exec_cmd_o,
  input  logic                exec_done_i,
  input  logic [1:0]          exec_result_i,
  output logic                floppy_o,
  output logic [1:0]          drive_o,
  output logic [2:0]          head_o,
  output logic [2*DATA_W-1:0] track_o,
  output logic [DATA_W-1:0]   sector_o
);
  logic rd_rise, wr_rise;
  logic busy, drq, err, buf_last, ptr_clear, ptr_step;
  logic [DATA_W-1:0] err_reg, tf_rdata, status;
  port_e sel;

  assign sel = port_e'(port_sel_i);

  dkc_strobe_edge u_rd_edge (.clk_i, .rst_ni, .level_i(rd_i), .rise_o(rd_rise));
  dkc_strobe_edge u_wr_edge (.clk_i, .rst_ni, .level_i(wr_i), .rise_o(wr_rise));

  dkc_task_file #(.DATA_W(DATA_W)) u_tf (
    .clk_i, .rst_ni,
    .wr_en_i (wr_rise),
    .sel_i   (port_sel_i),
    .din_i,
    .rdata_o (tf_rdata),
    .floppy_o, .drive_o, .head_o, .track_o, .sector_o
  );

  dkc_buf_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk_i, .rst_ni,
    .clear_i (ptr_clear),
    .step_i  (ptr_step),
    .addr_o  (buf_addr_o),
    .last_o  (buf_last)
  );

  dkc_cmd_ctl #(.DATA_W(DATA_W)) u_ctl (
    .clk_i, .rst_ni,
    .cmd_wr_i    (wr_rise && sel == P_CMD),
    .data_rd_i   (rd_rise && sel == P_DATA),
    .data_wr_i   (wr_rise && sel == P_DATA),
    .din_i,
    .buf_last_i  (buf_last),
    .done_i      (exec_done_i),
    .result_i    (exec_result_i),
    .busy_o      (busy),
    .drq_o       (drq),
    .err_o       (err),
    .err_reg_o   (err_reg),
    .exec_req_o,
    .exec_cmd_o,
    .ptr_clear_o (ptr_clear),
    .ptr_step_o  (ptr_step),
    .buf_we_o,
    .buf_wdata_o
  );

  // ready and seek-complete are always asserted
  assign status = {busy, 1'b1, 1'b0, 1'b1, drq, 2'b00, err};

  always_comb begin
    unique case (sel)
      P_DATA:  dout_o = buf_rdata_i;
      P_ERR:   dout_o = err_reg;
      P_CMD:   dout_o = status;
      default: dout_o = tf_rdata;
    endcase
  end
endmodule

// File: tb/sim_dkc_host_regs.sv
module sim_dkc_host_regs;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] sel = '0;
  logic rd = 1'b0, wr = 1'b0;
  logic [7:0] din = '0, dout;
  logic [8:0] baddr;
  logic bwe;
  logic [7:0] bwdata, brdata;
  logic req;
  logic [7:0] cmd;
  logic done = 1'b0;
  logic [1:0] res = '0;
  logic floppy;
  logic [1:0] drive;
  logic [2:0] head;
  logic [15:0] track;
  logic [7:0] sector;

  always #(CLK_PERIOD/2) clk = ~clk;

  dkc_host_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .port_sel_i(sel), .rd_i(rd), .wr_i(wr),
    .din_i(din), .dout_o(dout), .buf_addr_o(baddr), .buf_we_o(bwe),
    .buf_wdata_o(bwdata), .buf_rdata_i(brdata), .exec_req_o(req),
    .exec_cmd_o(cmd), .exec_done_i(done), .exec_result_i(res),
    .floppy_o(floppy), .drive_o(drive), .head_o(head), .track_o(track),
    .sector_o(sector)
  );

  // buffer RAM model with a fill port for the sequencer model
  logic [7:0] mem [512];
  logic [7:0] exp_buf [512];
  logic fill_en = 1'b0;
  logic [8:0] fill_addr = '0;
  logic [7:0] fill_data = '0;
  logic [7:0] ram_q = '0;
  always @(posedge clk) begin
    if (bwe) mem[baddr] <= bwdata;
    if (fill_en) mem[fill_addr] <= fill_data;
    ram_q <= mem[baddr];
  end
  assign brdata = ram_q;

  int req_cnt = 0;
  logic [7:0] last_cmd = '0;
  always @(posedge clk) if (req) begin req_cnt++; last_cmd = cmd; end

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] shadow [2:6];

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", r, act, exp);
    end
  endtask

  function automatic logic [7:0] stat(input bit b, input bit q, input bit e);
    return {b, 1'b1, 1'b0, 1'b1, q, 2'b00, e};
  endfunction

  task automatic io_wr(input logic [2:0] p, input logic [7:0] d, input int hold = 2);
    @(negedge clk); sel = p; din = d; wr = 1'b1;
    repeat (hold) @(negedge clk);
    wr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic io_rd(input logic [2:0] p, output logic [7:0] d, input int hold = 2);
    @(negedge clk); sel = p; rd = 1'b1;
    @(negedge clk); d = dout;
    repeat (hold) @(negedge clk);
    rd = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic complete(input logic [1:0] r);
    @(negedge clk); done = 1'b1; res = r;
    @(negedge clk); done = 1'b0; res = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic fill_buf();
    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      exp_buf[i] = 8'($urandom);
      fill_en = 1'b1; fill_addr = 9'(i); fill_data = exp_buf[i];
    end
    @(negedge clk); fill_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v, sdh;
    int rc, p;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    io_rd(3'd7, v); chk("R11 reset status", v, 8'h50);
    io_rd(3'd1, v); chk("R11 reset error reg", v, 0);
    chk("R11 reset addr", baddr, 0);
    chk("R11 reset req", req, 0);
    for (int i = 2; i <= 6; i++) begin
      io_rd(3'(i), v); chk("R11 reset task file", v, 0);
      shadow[i] = 8'h00;
    end

    // R1 register file
    for (int k = 0; k < 20; k++) begin
      p = 2 + int'($urandom % 5);
      v = 8'($urandom);
      io_wr(3'(p), v);
      shadow[p] = v;
    end
    for (int i = 2; i <= 6; i++) begin
      io_rd(3'(i), v); chk("R1 readback", v, shadow[i]);
    end
    io_wr(3'd1, 8'hFF);
    io_rd(3'd1, v); chk("R1 error port write ignored", v, 0);
    chk("R2 track", track, {shadow[5], shadow[4]});
    chk("R2 sector", sector, shadow[3]);

    // R2 drive decode
    for (int k = 0; k < 18; k++) begin
      sdh = (k == 0) ? 8'h0D : (k == 1) ? 8'h1B : 8'($urandom);
      io_wr(3'd6, sdh);
      if (sdh[4:3] == 2'b11) begin
        chk("R2 floppy flag", floppy, 1);
        chk("R2 floppy drive", drive, sdh[2:1]);
        chk("R2 floppy head", head, {2'b00, sdh[0]});
      end else begin
        chk("R2 hard flag", floppy, 0);
        chk("R2 hard drive", drive, sdh[4:3]);
        chk("R2 hard head", head, sdh[2:0]);
      end
    end

    // R4 / R7 read command
    fill_buf();
    rc = req_cnt;
    io_wr(3'd7, 8'h20);
    chk("R4 req count", req_cnt, rc + 1);
    chk("R4 req cmd", last_cmd, 8'h20);
    io_rd(3'd7, v); chk("R4 busy status", v, stat(1, 0, 0));
    io_wr(3'd7, 8'h30);
    chk("R7 no req while busy", req_cnt, rc + 1);
    io_rd(3'd7, v); chk("R7 status unchanged", v, stat(1, 0, 0));
    io_rd(3'd0, v);
    chk("R8 data read while busy keeps addr", baddr, 0);
    complete(2'd0);
    io_rd(3'd7, v); chk("R10 read ok sets drq", v, stat(0, 1, 0));

    // R5 drain, R3 long strobe on first read
    for (int i = 0; i < 512; i++) begin
      io_rd(3'd0, v, (i == 0) ? 8 : 2);
      chk("R5 drain byte", v, exp_buf[i]);
      if (i == 0) chk("R3 long read strobe one step", baddr, 1);
      if (i == 510) begin
        io_rd(3'd7, v); chk("R5 drq held before last", v, stat(0, 1, 0));
      end
    end
    io_rd(3'd7, v); chk("R5 drq clear after last", v, stat(0, 0, 0));
    chk("R5 addr wrapped", baddr, 0);

    // R6 write command
    rc = req_cnt;
    io_wr(3'd7, 8'h30);
    io_rd(3'd7, v); chk("R6 write drq", v, stat(0, 1, 0));
    chk("R6 no early req", req_cnt, rc);
    for (int i = 0; i < 512; i++) begin
      exp_buf[i] = 8'($urandom);
      io_wr(3'd0, exp_buf[i], (i == 0) ? 8 : 2);
      if (i == 0) chk("R3 long write strobe one step", baddr, 1);
      if (i == 510) begin
        chk("R6 no req at 511", req_cnt, rc);
        io_rd(3'd7, v); chk("R6 drq at 511", v, stat(0, 1, 0));
      end
    end
    chk("R6 req at 512", req_cnt, rc + 1);
    chk("R6 req cmd", last_cmd, 8'h30);
    io_rd(3'd7, v); chk("R6 busy after fill", v, stat(1, 0, 0));
    rc = 0;
    for (int i = 0; i < 512; i++) if (mem[i] != exp_buf[i]) rc++;
    chk("R6 buffer contents mismatches", rc, 0);
    complete(2'd0);
    io_rd(3'd7, v); chk("R10 write ok idle", v, stat(0, 0, 0));

    // R8 address reset by command
    fill_buf();
    io_wr(3'd7, 8'h20); complete(2'd0);
    for (int i = 0; i < 5; i++) io_rd(3'd0, v);
    chk("R8 addr mid drain", baddr, 5);
    io_wr(3'd7, 8'h20);
    chk("R8 command clears addr", baddr, 0);

    // R10 faults
    complete(2'd1);
    io_rd(3'd7, v); chk("R10 geo status", v, stat(0, 0, 1));
    io_rd(3'd1, v); chk("R10 geo err reg", v, 8'h10);
    io_wr(3'd7, 8'h20);
    io_rd(3'd1, v); chk("R10 command clears err", v, 0);
    complete(2'd2);
    io_rd(3'd7, v); chk("R10 storage status", v, stat(0, 0, 1));
    io_rd(3'd1, v); chk("R10 storage err reg", v, 8'h40);

    // R9 unsupported commands
    rc = req_cnt;
    io_wr(3'd7, 8'h70);
    io_rd(3'd7, v); chk("R9 bad cmd status", v, stat(0, 0, 1));
    io_rd(3'd1, v); chk("R9 abort bit", v, 8'h04);
    io_wr(3'd7, 8'h5A);
    chk("R9 no req", req_cnt, rc);

    // R10 done while idle is ignored
    io_wr(3'd7, 8'h30);
    complete(2'd1);
    io_rd(3'd7, v); chk("R10 idle done ignored", v, stat(0, 1, 0));
    io_wr(3'd0, 8'hA5);
    chk("R8 write port advances in write mode", baddr, 1);

    finish_run();
  end
endmodule